// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block holds one pending flag per interrupt source. A hardware event or a software set pulse can raise each flag. When the core's status word has its global enable bit on, the block picks one enabled pending source and walks a small 16-bit CPU through exception entry. Entry writes the program counter and then the status word onto a descending memory stack. It loads the status word back with the global enable cleared, reads the handler address from a vector table and loads that address into the program counter. A return request from the core runs the reverse sequence: it reads the status word and then the program counter back from the stack and releases the two stack words.

The core keeps its program counter, status word and stack pointer. The sequencer reads them through readback inputs and writes them through load strobes. All stack and vector traffic uses one synchronous memory port, where read data is valid in the cycle after the request. Sources named in a parameter share a vector with other sources. Their flags stay set through entry, and the handler must clear them. Sources named in a second parameter are asynchronous to the clock and pass through a two-flop synchronizer.

Top module: `irq_entry_seq`

## Requirements
- R1: A pending flag is set by a hardware event or by a software set pulse and is visible on `pend_flags` after the next clock edge. A software clear pulse drops it. When a set and a clear reach the same flag in the same cycle, the set wins.
- R2: A source is accepted only when its flag and its `irq_en` bit are both 1, the sequencer is idle, and bit 3 of `sr_in` (global enable) is 1. Otherwise `busy` stays 0 and no memory access starts.
- R3: Among the accepted candidates, the source with the highest index wins, whatever order the flags arrived in. `act_id` reports the winner.
- R4: One cycle after acceptance, the sequencer writes `pc_in` to address SP-2. In the next cycle it writes `sr_in` to address SP-4, where SP is `sp_in` at acceptance. Entry makes exactly these two writes.
- R5: In the same cycle as the status-word push, `sr_ld` is 1 and `sr_out` equals the captured status word with bit 3 cleared. In that cycle `sp_ld` is 1 and `sp_out` is SP-4. No new acceptance follows until the core sets bit 3 again.
- R6: In the third cycle after acceptance, the sequencer reads address `VEC_BASE` + 2*k, where k is the winner's index and `VEC_BASE` defaults to 0xFFE0. In the fourth cycle, `pc_ld` and `entry_done` are 1 and `pc_out` is the word read. The sequencer is idle in the next cycle.
- R7: A source whose bit in `SHARED_MASK` is 0 has its flag cleared at the clock edge that ends the vector read. A source whose bit is 1 keeps its flag. The default `SHARED_MASK` is 0x24, so sources 2 and 5 share a vector.
- R8: When idle, a `reti_req` pulse starts a return. Given SP = `sp_in` at that point, the sequencer reads SP in the next cycle. In the cycle after that, it loads the word read into `sr_out` with `sr_ld` and reads SP+2. In the following cycle, it loads that word into `pc_out` with `pc_ld`, drives `sp_out` = SP+4 with `sp_ld`, and asserts `reti_done`. A return request takes precedence over a pending interrupt.
- R9: A source whose bit in `SYNC_MASK` is 1 sets its flag from `hw_evt` three clock edges after the event is sampled, not one. The default `SYNC_MASK` is 0x80, which covers source 7 only.
- R10: A hardware event that arrives in the vector-read cycle for the same single-vector source keeps that flag set. A new request raised while entry is running does not change `act_id` for the entry already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_evt | input | NSRC | Hardware event per source (level, sets flag) |
| sw_set | input | NSRC | Software set pulse per flag |
| sw_clr | input | NSRC | Software clear pulse per flag |
| irq_en | input | NSRC | Per-source enable mask |
| reti_req | input | 1 | Return-from-interrupt request |
| pc_in | input | XW | Core program counter readback |
| sr_in | input | XW | Core status word readback |
| sp_in | input | XW | Core stack pointer readback |
| pc_ld | output | 1 | Load strobe for program counter |
| pc_out | output | XW | Program counter load value |
| sr_ld | output | 1 | Load strobe for status word |
| sr_out | output | XW | Status word load value |
| sp_ld | output | 1 | Load strobe for stack pointer |
| sp_out | output | XW | Stack pointer load value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | XW | Memory byte address |
| mem_wdata | output | XW | Memory write data |
| mem_rdata | input | XW | Memory read data, valid the cycle after a read |
| pend_flags | output | NSRC | Pending flag vector |
| busy | output | 1 | Entry or return sequence in progress |
| entry_done | output | 1 | One-cycle strobe when handler address is loaded |
| reti_done | output | 1 | One-cycle strobe when return completes |
| act_id | output | IDW | Index of the source being or last serviced |

## Verification
The automatic clear of a serviced flag and a fresh hardware event on that same source can both land on the clock edge that ends the vector read. The bench provokes this by holding the event for source 3 across exactly that edge. It judges the result from `pend_flags` in the same cycle that `pc_ld` rises, where the flag must still read 1. A second overlap occurs when a higher-index software set arrives during the push cycles. The bench checks that the entry in progress keeps its original `act_id` and that the newer flag stays pending without a nested entry.

// File: rtl/irq_pkg.sv
package irq_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_PUSH_PC,
      S_PUSH_SR,
      S_VEC_RD,
      S_VEC_LD,
      S_POP_SR,
      S_POP_PC,
      S_POP_LD
   } seq_state_t;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int                NSRC        = 8,
   parameter logic [NSRC-1:0]   SYNC_MASK   = '0,
   parameter logic [NSRC-1:0]   SHARED_MASK = '0,
   localparam int               IDW         = irq_pkg::idx_width(NSRC)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] hw_evt,
   input  logic [NSRC-1:0] sw_set,
   input  logic [NSRC-1:0] sw_clr,
   input  logic            clr_valid,
   input  logic [IDW-1:0]  clr_id,
   output logic [NSRC-1:0] flags
);

   logic [NSRC-1:0] evt_s;
   logic [NSRC-1:0] auto_hit;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      if (SYNC_MASK[i]) begin : g_sync
         logic meta_q, sync_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               meta_q <= 1'b0;
               sync_q <= 1'b0;
            end else begin
               meta_q <= hw_evt[i];
               sync_q <= meta_q;
            end
         end
         assign evt_s[i] = sync_q;

         // R9
         sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(flags[i]) && !$past(sw_set[i])) |-> $past(hw_evt[i], 3));
      end else begin : g_direct
         assign evt_s[i] = hw_evt[i];
      end

      if (SHARED_MASK[i]) begin : g_shared
         assign auto_hit[i] = 1'b0;
      end else begin : g_single
         assign auto_hit[i] = clr_valid && (clr_id == IDW'(i));
      end

      always_ff @(posedge clk) begin
         if (!rst_n) flags[i] <= 1'b0;
         else        flags[i] <= (flags[i] & ~sw_clr[i] & ~auto_hit[i])
                                 | evt_s[i] | sw_set[i];
      end

      // R1
      flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(flags[i]) && !$past(sw_clr[i]) && !$past(auto_hit[i])) |-> flags[i]);
   end

endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
   parameter  int NSRC = 8,
   localparam int IDW  = irq_pkg::idx_width(NSRC)
) (
   input  logic [NSRC-1:0] req,
   output logic            valid,
   output logic [IDW-1:0]  idx
);

   always_comb begin
      idx   = '0;
      valid = |req;
      for (int i = 0; i < NSRC; i++) begin
         if (req[i]) idx = IDW'(i);
      end
   end

   // R3
   always_comb begin
      prio_top_chk: assert (!valid || ((req >> idx) == NSRC'(1)));
   end

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
   import irq_pkg::*;
#(
   parameter  int           NSRC     = 8,
   parameter  int           XW       = 16,
   parameter  int           GIE_BIT  = 3,
   parameter  logic [XW-1:0] VEC_BASE = 16'hFFE0,
   localparam int           IDW      = idx_width(NSRC),
   localparam int           WSTEP    = XW / 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           win_valid,
   input  logic [IDW-1:0] win_idx,
   input  logic           reti_req,
   input  logic [XW-1:0]  pc_in,
   input  logic [XW-1:0]  sr_in,
   input  logic [XW-1:0]  sp_in,
   input  logic [XW-1:0]  mem_rdata,
   output logic           mem_req,
   output logic           mem_we,
   output logic [XW-1:0]  mem_addr,
   output logic [XW-1:0]  mem_wdata,
   output logic           pc_ld,
   output logic [XW-1:0]  pc_out,
   output logic           sr_ld,
   output logic [XW-1:0]  sr_out,
   output logic           sp_ld,
   output logic [XW-1:0]  sp_out,
   output logic           busy,
   output logic           entry_done,
   output logic           reti_done,
   output logic           clr_valid,
   output logic [IDW-1:0] clr_id,
   output logic [IDW-1:0] act_id
);

   localparam logic [XW-1:0] GIE_MASK = XW'(1) << GIE_BIT;
   localparam logic [XW-1:0] STEP     = XW'(WSTEP);

   seq_state_t     state;
   logic [XW-1:0]  cap_pc, cap_sr, cap_sp;
   logic [IDW-1:0] cap_id;
   logic [XW-1:0]  vec_addr;

   assign vec_addr = VEC_BASE + XW'(cap_id) * STEP;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         cap_pc <= '0;
         cap_sr <= '0;
         cap_sp <= '0;
         cap_id <= '0;
      end else begin
         unique case (state)
            S_IDLE: begin
               if (reti_req) begin
                  cap_sp <= sp_in;
                  state  <= S_POP_SR;
               end else if (win_valid && sr_in[GIE_BIT]) begin
                  cap_pc <= pc_in;
                  cap_sr <= sr_in;
                  cap_sp <= sp_in;
                  cap_id <= win_idx;
                  state  <= S_PUSH_PC;
               end
            end
            S_PUSH_PC: state <= S_PUSH_SR;
            S_PUSH_SR: state <= S_VEC_RD;
            S_VEC_RD:  state <= S_VEC_LD;
            S_VEC_LD:  state <= S_IDLE;
            S_POP_SR:  state <= S_POP_PC;
            S_POP_PC:  state <= S_POP_LD;
            S_POP_LD:  state <= S_IDLE;
            default:   state <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req    = 1'b0;
      mem_we     = 1'b0;
      mem_addr   = '0;
      mem_wdata  = '0;
      pc_ld      = 1'b0;
      pc_out     = '0;
      sr_ld      = 1'b0;
      sr_out     = '0;
      sp_ld      = 1'b0;
      sp_out     = '0;
      entry_done = 1'b0;
      reti_done  = 1'b0;
      clr_valid  = 1'b0;
      unique case (state)
         S_PUSH_PC: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cap_sp - STEP;
            mem_wdata = cap_pc;
         end
         S_PUSH_SR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cap_sp - 2 * STEP;
            mem_wdata = cap_sr;
            sr_ld     = 1'b1;
            sr_out    = cap_sr & ~GIE_MASK;
            sp_ld     = 1'b1;
            sp_out    = cap_sp - 2 * STEP;
         end
         S_VEC_RD: begin
            mem_req   = 1'b1;
            mem_addr  = vec_addr;
            clr_valid = 1'b1;
         end
         S_VEC_LD: begin
            pc_ld      = 1'b1;
            pc_out     = mem_rdata;
            entry_done = 1'b1;
         end
         S_POP_SR: begin
            mem_req  = 1'b1;
            mem_addr = cap_sp;
         end
         S_POP_PC: begin
            mem_req  = 1'b1;
            mem_addr = cap_sp + STEP;
            sr_ld    = 1'b1;
            sr_out   = mem_rdata;
         end
         S_POP_LD: begin
            pc_ld     = 1'b1;
            pc_out    = mem_rdata;
            sp_ld     = 1'b1;
            sp_out    = cap_sp + 2 * STEP;
            reti_done = 1'b1;
         end
         default: ;
      endcase
   end

   assign busy   = (state != S_IDLE);
   assign clr_id = cap_id;
   assign act_id = cap_id;

   // R2
   accept_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_PUSH_PC) |-> ($past(sr_in[GIE_BIT]) && $past(win_valid)));

   // R4
   push_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_PUSH_SR) |-> (mem_we && $past(mem_we) && mem_addr == $past(mem_addr) - STEP));

   // R5
   gie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_ld && mem_we) |-> !sr_out[GIE_BIT]);

   // R6
   vec_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      entry_done |-> ($past(mem_req) && !$past(mem_we) && $past(mem_addr) == vec_addr));

   // R8
   pop_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reti_done |-> (sp_out == $past(mem_addr) + STEP));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
   parameter  int               NSRC        = 8,
   parameter  int               XW          = 16,
   parameter  int               GIE_BIT     = 3,
   parameter  logic [XW-1:0]    VEC_BASE    = 16'hFFE0,
   parameter  logic [NSRC-1:0]  SYNC_MASK   = 8'h80,
   parameter  logic [NSRC-1:0]  SHARED_MASK = 8'h24,
   localparam int               IDW         = irq_pkg::idx_width(NSRC)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] hw_evt,
   input  logic [NSRC-1:0] sw_set,
   input  logic [NSRC-1:0] sw_clr,
   input  logic [NSRC-1:0] irq_en,
   input  logic            reti_req,
   input  logic [XW-1:0]   pc_in,
   input  logic [XW-1:0]   sr_in,
   input  logic [XW-1:0]   sp_in,
   output logic            pc_ld,
   output logic [XW-1:0]   pc_out,
   output logic            sr_ld,
   output logic [XW-1:0]   sr_out,
   output logic            sp_ld,
   output logic [XW-1:0]   sp_out,
   output logic            mem_req,
   output logic            mem_we,
   output logic [XW-1:0]   mem_addr,
   output logic [XW-1:0]   mem_wdata,
   input  logic [XW-1:0]   mem_rdata,
   output logic [NSRC-1:0] pend_flags,
   output logic            busy,
   output logic            entry_done,
   output logic            reti_done,
   output logic [IDW-1:0]  act_id
);

   if (NSRC < 2) begin : g_bad_nsrc
      $error("NSRC must be at least 2");
   end
   if (XW < 8 || (XW % 8) != 0) begin : g_bad_xw
      $error("XW must be a positive multiple of 8");
   end
   if (GIE_BIT < 0 || GIE_BIT >= XW) begin : g_bad_gie
      $error("GIE_BIT must lie inside the status word");
   end
   if ((VEC_BASE % (XW / 8)) != 0) begin : g_bad_base
      $error("VEC_BASE must be word aligned");
   end

   logic           win_valid;
   logic [IDW-1:0] win_idx;
   logic           clr_valid;
   logic [IDW-1:0] clr_id;

   irq_flag_bank #(
      .NSRC        (NSRC),
      .SYNC_MASK   (SYNC_MASK),
      .SHARED_MASK (SHARED_MASK)
   ) flags_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .hw_evt    (hw_evt),
      .sw_set    (sw_set),
      .sw_clr    (sw_clr),
      .clr_valid (clr_valid),
      .clr_id    (clr_id),
      .flags     (pend_flags)
   );

   irq_prio #(
      .NSRC (NSRC)
   ) prio_i (
      .req   (pend_flags & irq_en),
      .valid (win_valid),
      .idx   (win_idx)
   );

   irq_entry_fsm #(
      .NSRC     (NSRC),
      .XW       (XW),
      .GIE_BIT  (GIE_BIT),
      .VEC_BASE (VEC_BASE)
   ) fsm_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .win_valid  (win_valid),
      .win_idx    (win_idx),
      .reti_req   (reti_req),
      .pc_in      (pc_in),
      .sr_in      (sr_in),
      .sp_in      (sp_in),
      .mem_rdata  (mem_rdata),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .pc_ld      (pc_ld),
      .pc_out     (pc_out),
      .sr_ld      (sr_ld),
      .sr_out     (sr_out),
      .sp_ld      (sp_ld),
      .sp_out     (sp_out),
      .busy       (busy),
      .entry_done (entry_done),
      .reti_done  (reti_done),
      .clr_valid  (clr_valid),
      .clr_id     (clr_id),
      .act_id     (act_id)
   );

endmodule

// File: tb/irq_entry_seq_tb_top.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;

   localparam logic [7:0] SHARED = 8'h24;
   localparam logic [7:0] SYNCM  = 8'h80;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  hw_evt = '0, sw_set = '0, sw_clr = '0, irq_en = '0;
   logic        reti_req = 1'b0;
   logic [15:0] pc_r, sr_r, sp_r;
   logic        pc_ld, sr_ld, sp_ld, mem_req, mem_we, busy, entry_done, reti_done;
   logic [15:0] pc_out, sr_out, sp_out, mem_addr, mem_wdata, mem_rdata;
   logic [7:0]  pend_flags;
   logic [2:0]  act_id;
   logic [15:0] mem [256];

   int nchk = 0;
   int nfail = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   irq_entry_seq #(
      .SYNC_MASK   (SYNCM),
      .SHARED_MASK (SHARED)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .sw_set(sw_set), .sw_clr(sw_clr),
      .irq_en(irq_en), .reti_req(reti_req), .pc_in(pc_r), .sr_in(sr_r), .sp_in(sp_r),
      .pc_ld(pc_ld), .pc_out(pc_out), .sr_ld(sr_ld), .sr_out(sr_out),
      .sp_ld(sp_ld), .sp_out(sp_out), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .pend_flags(pend_flags), .busy(busy), .entry_done(entry_done),
      .reti_done(reti_done), .act_id(act_id)
   );

   // core register model and synchronous memory model
   always @(posedge clk) begin
      if (pc_ld) pc_r <= pc_out;
      if (sr_ld) sr_r <= sr_out;
      if (sp_ld) sp_r <= sp_out;
      if (mem_req && mem_we)  mem[mem_addr[8:1]] <= mem_wdata;
      if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[8:1]];
   end

   function automatic logic [15:0] vec_val(input int k);
      return 16'hA000 + 16'(k) * 16'h0111;
   endfunction

   function automatic int top_bit(input logic [7:0] v);
      int r = -1;
      for (int i = 0; i < 8; i++) if (v[i]) r = i;
      return r;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // Runs one entry whose acceptance edge is the next posedge; checks every cycle.
   task automatic entry_seq(input int k, input logic [15:0] pc0, input logic [15:0] sr0,
                            input logic [7:0] flags_before, input bit inject_evt);
      logic [7:0] fexp;
      step();
      chk(busy && mem_req && mem_we && mem_addr == 16'h00FE, "R4 pc push addr", mem_addr, 16'h00FE);
      chk(mem_wdata == pc0, "R4 pc push data", mem_wdata, pc0);
      step();
      chk(mem_we && mem_addr == 16'h00FC && mem_wdata == sr0, "R4 sr push", mem_wdata, sr0);
      chk(sr_ld && sr_out == (sr0 & 16'hFFF7), "R5 gie cleared", sr_out, sr0 & 16'hFFF7);
      chk(sp_ld && sp_out == 16'h00FC, "R5 sp load", sp_out, 16'h00FC);
      step();
      chk(mem_req && !mem_we && mem_addr == 16'hFFE0 + 16'(2 * k), "R6 vector addr",
          mem_addr, 16'hFFE0 + 16'(2 * k));
      if (inject_evt) hw_evt[k] = 1'b1;
      step();
      hw_evt = '0;
      chk(pc_ld && entry_done && pc_out == vec_val(k), "R6 pc load", pc_out, vec_val(k));
      chk(act_id == 3'(k), "R3 winner id", act_id, k);
      fexp = flags_before;
      if (!SHARED[k] && !inject_evt) fexp[k] = 1'b0;
      chk(pend_flags == fexp, inject_evt ? "R10 event vs auto clear" : "R7 flag clear rule",
          pend_flags, fexp);
      step();
      chk(!busy && !mem_req, "R6 back to idle", busy, 0);
   endtask

   task automatic reti_seq(input logic [15:0] pc0, input logic [15:0] sr0);
      reti_req = 1'b1;
      step();
      reti_req = 1'b0;
      chk(mem_req && !mem_we && mem_addr == 16'h00FC, "R8 sr pop addr", mem_addr, 16'h00FC);
      step();
      chk(sr_ld && sr_out == sr0, "R8 sr restore", sr_out, sr0);
      chk(mem_req && mem_addr == 16'h00FE, "R8 pc pop addr", mem_addr, 16'h00FE);
      step();
      chk(pc_ld && pc_out == pc0 && reti_done, "R8 pc restore", pc_out, pc0);
      chk(sp_ld && sp_out == 16'h0100, "R8 sp restore", sp_out, 16'h0100);
   endtask

   initial begin
      pc_r = 16'h4000; sr_r = '0; sp_r = 16'h0100; mem_rdata = '0;
      for (int i = 0; i < 256; i++) mem[i] = '0;
      for (int k = 0; k < 8; k++) mem[8'hF0 + k] = vec_val(k);
      repeat (4) step();
      rst_n = 1'b1;
      step();
      chk(pend_flags == 8'h00 && !busy && !mem_req, "R1 reset state", pend_flags, 0);

      // sweep over all nonzero flag patterns with varied enable masks
      for (int p = 1; p < 256; p++) begin
         logic [7:0]  pv, m;
         logic [15:0] pc0, sr0;
         int          k;
         pv  = 8'(p);
         m   = 8'((p * 29) ^ 8'hC3) | ((p % 5 == 0) ? 8'h00 : 8'h11);
         pc0 = 16'h4000 + 16'(2 * p);
         sr0 = 16'h0008 | {pv, 8'h00};
         k   = top_bit(pv & m);
         step();
         sr_r = '0; pc_r = pc0; sp_r = 16'h0100; sw_set = pv; irq_en = m;
         step();
         sw_set = '0;
         chk(pend_flags == pv, "R1 flags set by software", pend_flags, pv);
         sr_r = sr0;
         if (k < 0) begin
            step(); step();
            chk(!busy && !mem_req && pend_flags == pv, "R2 masked requests ignored", busy, 0);
            sw_clr = 8'hFF;
            step();
            sw_clr = '0;
         end else begin
            entry_seq(k, pc0, sr0, pv, 1'b0);
            sw_clr = 8'hFF;
            step();
            sw_clr = '0;
            reti_seq(pc0, sr0);
         end
      end

      // R2: global enable off blocks everything
      step();
      sr_r = 16'h0000; sw_set = 8'hFF; irq_en = 8'hFF;
      step();
      sw_set = '0;
      repeat (3) step();
      chk(!busy && !mem_req, "R2 global enable off", busy, 0);
      sw_clr = 8'hFF;
      step();
      sw_clr = '0;

      // R1: set and clear together -> set wins
      sw_set = 8'h10; sw_clr = 8'h10;
      step();
      sw_set = '0; sw_clr = '0;
      chk(pend_flags == 8'h10, "R1 set beats clear", pend_flags, 8'h10);
      sw_clr = 8'hFF;
      step();
      sw_clr = '0;

      // R9: synchronised source 7 vs direct source 0
      hw_evt = 8'h81;
      step();
      hw_evt = '0;
      chk(pend_flags == 8'h01, "R9 direct source after one edge", pend_flags, 8'h01);
      step();
      chk(pend_flags == 8'h01, "R9 synced source not yet", pend_flags, 8'h01);
      step();
      chk(pend_flags == 8'h81, "R9 synced source after three edges", pend_flags, 8'h81);
      sw_clr = 8'hFF;
      step();
      sw_clr = '0;

      // R10: hardware event on source 3 in its own vector-read cycle
      pc_r = 16'h5000; sp_r = 16'h0100; sw_set = 8'h08; irq_en = 8'h08;
      step();
      sw_set = '0;
      sr_r = 16'h0008;
      entry_seq(3, 16'h5000, 16'h0008, 8'h08, 1'b1);
      sw_clr = 8'hFF;
      step();
      sw_clr = '0;
      reti_seq(16'h5000, 16'h0008);

      // R10/R5: later higher request during entry keeps id, no nesting
      step();
      sr_r = '0; pc_r = 16'h6000; sp_r = 16'h0100; sw_set = 8'h02; irq_en = 8'hFF;
      step();
      sw_set = '0;
      sr_r = 16'h0008;
      step();
      sw_set = 8'h40;
      step();
      sw_set = '0;
      step(); step();
      chk(entry_done && act_id == 3'd1, "R10 id kept during entry", act_id, 1);
      step(); step();
      chk(!busy && pend_flags == 8'h40, "R5 no nested entry", {busy, pend_flags}, 8'h40);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog R6 sequence hung actual=%h expected=%h", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

endmodule